// File: doc/BRIEF.md
# Clocked Controller for an Asynchronous Byte-Wide Static RAM

This block connects a simple synchronous request port to an external asynchronous static RAM with 32768 byte locations. A client offers one request at a time with a valid/ready handshake: a 15-bit address, a direction flag and, for stores, a data byte. The controller then drives the memory's active-low select, write strobe and output enable. It also drives the memory data pins through a separate drive-enable. Every phase of the pin sequence lasts a whole number of clock cycles, and each count is set by a parameter. This lets one netlist meet the timing of slower or faster memory grades without any analog modelling.

A load holds output enable low for a programmable access window and registers the data bus on the last cycle of that window. The byte comes back with a one-cycle valid strobe. A store keeps output enable inactive for the whole cycle. It waits a turnaround window before driving the bus, then holds the data for a setup window before the write strobe falls, and releases the bus in the same cycle that the strobe rises. Every access ends with a recovery window in which all strobes are inactive. After that, select goes high and the memory drops into standby until the next request.

Top module: `sram_ctrl`

## Requirements
- R1: After reset, and whenever no access is in progress, mem_cs_n, mem_we_n and mem_oe_n are 1, mem_dq_oe is 0, req_ready is 1 and rsp_valid is 0. A reset applied in the middle of an access returns the pins to this state on the next clock edge.
- R2: During a load, mem_oe_n is 0 only together with mem_cs_n=0 and mem_we_n=1. It stays 0 for exactly ACCESS_CYC consecutive cycles, and the memory address equals the requested address.
- R3: On the last cycle of the access window, the controller registers the data bus. rsp_data carries that byte while rsp_valid is 1 for exactly one cycle. A request accepted at clock edge E0 gives rsp_valid=1 after edge E0+ACCESS_CYC.
- R4: During a store, mem_we_n is 0 for exactly PULSE_CYC consecutive cycles. mem_cs_n is 0 and mem_oe_n is 1 throughout, so the memory stores the byte at the requested address.
- R5: mem_dq_oe is 1 only during stores and never while mem_oe_n is 0. It rises only after at least TURN_CYC cycles in which mem_cs_n=0 and mem_oe_n=1.
- R6: mem_dq_oe is 1 for exactly SETUP_CYC cycles before mem_we_n falls. It stays 1 while mem_we_n is 0 and drops in the same cycle that mem_we_n rises.
- R7: Each access ends with exactly RECOV_CYC cycles in which mem_cs_n=0 and all other strobes are inactive, before mem_cs_n returns to 1.
- R8: req_ready is 0 from acceptance until the access completes. A request held valid while req_ready is 0 is not taken, and it is taken once req_ready returns to 1.
- R9: mem_addr and mem_dq_out stay stable while mem_cs_n stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Controller can take a request |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | 15 | Byte address |
| req_wdata | input | 8 | Store data |
| rsp_valid | output | 1 | One-cycle strobe, load data valid |
| rsp_data | output | 8 | Load data |
| mem_addr | output | 15 | Memory address pins |
| mem_cs_n | output | 1 | Memory select, active low |
| mem_we_n | output | 1 | Memory write strobe, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_dq_out | output | 8 | Data driven toward the memory |
| mem_dq_oe | output | 1 | Drive enable for the data pins |
| mem_dq_in | input | 8 | Data read back from the memory pins |

## Verification
Two events can meet in the same cycle. The first is the recovery end that returns the controller to idle and raises req_ready. The second is a new request that the client has held valid since the previous access began. The bench keeps req_valid high across a store and switches the payload to a load of the same address while req_ready is low. It confirms that nothing is taken during the busy window, that the load is taken only after recovery, and that the load returns the byte just stored. A second collision puts a reset on a cycle where the write strobe is low. The bench judges it by the pins being idle on the following cycle.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD,
    ST_TURN,
    ST_SETUP,
    ST_PULSE,
    ST_RECOV
  } seq_state_t;

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/sram_phase_cnt.sv
module sram_phase_cnt #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             last
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (load)        cnt <= load_val;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign last = (cnt == '0);
endmodule

// File: rtl/sram_req_hold.sv
module sram_req_hold #(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              take,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [DATA_W-1:0] data_in,
  output logic [ADDR_W-1:0] addr_out,
  output logic [DATA_W-1:0] data_out
);
  always_ff @(posedge clk) begin
    if (rst) begin
      addr_out <= '0;
      data_out <= '0;
    end else if (take) begin
      addr_out <= addr_in;
      data_out <= data_in;
    end
  end
endmodule

// File: rtl/sram_rd_capture.sv
module sram_rd_capture #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              capture,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic              valid
);
  always_ff @(posedge clk) begin
    if (rst) begin
      dout  <= '0;
      valid <= 1'b0;
    end else begin
      valid <= capture;
      if (capture) dout <= din;
    end
  end
endmodule

// File: rtl/sram_seq.sv
module sram_seq
  import sram_ctrl_pkg::*;
#(
  parameter int CNT_W      = 4,
  parameter int SETUP_CYC  = 2,
  parameter int PULSE_CYC  = 3,
  parameter int RECOV_CYC  = 1,
  parameter int ACCESS_CYC = 2,
  parameter int TURN_CYC   = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic             cnt_last,
  output logic             req_ready,
  output logic             take,
  output logic             cnt_load,
  output logic [CNT_W-1:0] cnt_val,
  output logic             capture,
  output logic             cs_n,
  output logic             we_n,
  output logic             oe_n,
  output logic             dq_oe
);
  localparam logic [CNT_W-1:0] LD_SETUP  = CNT_W'(SETUP_CYC - 1);
  localparam logic [CNT_W-1:0] LD_PULSE  = CNT_W'(PULSE_CYC - 1);
  localparam logic [CNT_W-1:0] LD_RECOV  = CNT_W'(RECOV_CYC - 1);
  localparam logic [CNT_W-1:0] LD_ACCESS = CNT_W'(ACCESS_CYC - 1);
  localparam logic [CNT_W-1:0] LD_TURN   = CNT_W'(TURN_CYC - 1);

  seq_state_t state;
  logic       accept;

  assign accept  = (state == ST_IDLE) && req_valid && req_ready;
  assign take    = accept;
  assign capture = (state == ST_RD) && cnt_last;

  always_comb begin
    cnt_load = 1'b0;
    cnt_val  = '0;
    if (accept) begin
      cnt_load = 1'b1;
      cnt_val  = req_write ? LD_TURN : LD_ACCESS;
    end else if (cnt_last) begin
      unique case (state)
        ST_RD:    begin cnt_load = 1'b1; cnt_val = LD_RECOV; end
        ST_TURN:  begin cnt_load = 1'b1; cnt_val = LD_SETUP; end
        ST_SETUP: begin cnt_load = 1'b1; cnt_val = LD_PULSE; end
        ST_PULSE: begin cnt_load = 1'b1; cnt_val = LD_RECOV; end
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      req_ready <= 1'b1;
      cs_n      <= 1'b1;
      we_n      <= 1'b1;
      oe_n      <= 1'b1;
      dq_oe     <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: if (accept) begin
          req_ready <= 1'b0;
          cs_n      <= 1'b0;
          if (req_write) state <= ST_TURN;
          else begin
            state <= ST_RD;
            oe_n  <= 1'b0;
          end
        end
        ST_RD: if (cnt_last) begin
          oe_n  <= 1'b1;
          state <= ST_RECOV;
        end
        ST_TURN: if (cnt_last) begin
          dq_oe <= 1'b1;
          state <= ST_SETUP;
        end
        ST_SETUP: if (cnt_last) begin
          we_n  <= 1'b0;
          state <= ST_PULSE;
        end
        ST_PULSE: if (cnt_last) begin
          we_n  <= 1'b1;
          dq_oe <= 1'b0;
          state <= ST_RECOV;
        end
        ST_RECOV: if (cnt_last) begin
          cs_n      <= 1'b1;
          req_ready <= 1'b1;
          state     <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sram_ctrl.sv
module sram_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W     = 15,
  parameter int DATA_W     = 8,
  parameter int SETUP_CYC  = 2,
  parameter int PULSE_CYC  = 3,
  parameter int RECOV_CYC  = 1,
  parameter int ACCESS_CYC = 2,
  parameter int TURN_CYC   = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_cs_n,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in
);
  localparam int MAX_CYC = max2(max2(max2(SETUP_CYC, PULSE_CYC), max2(RECOV_CYC, ACCESS_CYC)), TURN_CYC);
  localparam int CNT_W   = $clog2(MAX_CYC) + 1;

  generate
    if (SETUP_CYC < 1 || PULSE_CYC < 1 || RECOV_CYC < 1 || ACCESS_CYC < 1 || TURN_CYC < 1) begin : g_bad_cfg
      $error("sram_ctrl: every phase count must be at least 1");
    end
  endgenerate

  logic             take;
  logic             cnt_load;
  logic [CNT_W-1:0] cnt_val;
  logic             cnt_last;
  logic             capture;

  sram_seq #(
    .CNT_W(CNT_W), .SETUP_CYC(SETUP_CYC), .PULSE_CYC(PULSE_CYC),
    .RECOV_CYC(RECOV_CYC), .ACCESS_CYC(ACCESS_CYC), .TURN_CYC(TURN_CYC)
  ) u_seq (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .cnt_last(cnt_last), .req_ready(req_ready), .take(take),
    .cnt_load(cnt_load), .cnt_val(cnt_val), .capture(capture),
    .cs_n(mem_cs_n), .we_n(mem_we_n), .oe_n(mem_oe_n), .dq_oe(mem_dq_oe)
  );

  sram_phase_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .load(cnt_load), .load_val(cnt_val), .last(cnt_last)
  );

  sram_req_hold #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_hold (
    .clk(clk), .rst(rst), .take(take), .addr_in(req_addr), .data_in(req_wdata),
    .addr_out(mem_addr), .data_out(mem_dq_out)
  );

  sram_rd_capture #(.DATA_W(DATA_W)) u_cap (
    .clk(clk), .rst(rst), .capture(capture), .din(mem_dq_in),
    .dout(rsp_data), .valid(rsp_valid)
  );
endmodule

// File: rtl/sram_ctrl_chk.sv
module sram_ctrl_chk #(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_cs_n,
  input logic              mem_we_n,
  input logic              mem_oe_n,
  input logic [DATA_W-1:0] mem_dq_out,
  input logic              mem_dq_oe
);
  assert_read_combo_R2: assert property (@(posedge clk) disable iff (rst)
    !mem_oe_n |-> (!mem_cs_n && mem_we_n));

  assert_single_strobe_R3: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

  assert_write_frame_R4: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |-> (!mem_cs_n && mem_oe_n && mem_dq_oe));

  assert_no_contention_R5: assert property (@(posedge clk) disable iff (rst)
    mem_dq_oe |-> mem_oe_n);

  assert_drive_after_turn_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_dq_oe) |-> ($past(mem_oe_n) && !$past(mem_cs_n)));

  assert_setup_before_strobe_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(mem_we_n) |-> $past(mem_dq_oe));

  assert_busy_not_ready_R8: assert property (@(posedge clk) disable iff (rst)
    !mem_cs_n |-> !req_ready);

  assert_pins_stable_R9: assert property (@(posedge clk) disable iff (rst)
    (!mem_cs_n && !$past(mem_cs_n)) |-> ($stable(mem_addr) && $stable(mem_dq_out)));
endmodule

bind sram_ctrl sram_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .req_ready(req_ready), .rsp_valid(rsp_valid),
  .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n),
  .mem_oe_n(mem_oe_n), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe)
);

// File: tb/test_sram_ctrl.sv
`timescale 1ns/1ps
module test_sram_ctrl;
  localparam int SETUP_CYC  = 2;
  localparam int PULSE_CYC  = 3;
  localparam int RECOV_CYC  = 1;
  localparam int ACCESS_CYC = 2;
  localparam int TURN_CYC   = 1;
  localparam int NVEC  = 10;
  localparam int SLOTS = 16;

  // {store flag, address, data (store) or expected byte (load)}
  localparam logic [23:0] VEC [0:NVEC-1] = '{
    {1'b1, 15'h0000, 8'hA5}, {1'b1, 15'h7FFF, 8'h5A}, {1'b1, 15'h1234, 8'h3C},
    {1'b0, 15'h0000, 8'hA5}, {1'b0, 15'h7FFF, 8'h5A}, {1'b1, 15'h0000, 8'hFF},
    {1'b0, 15'h1234, 8'h3C}, {1'b0, 15'h0000, 8'hFF}, {1'b1, 15'h4000, 8'h00},
    {1'b0, 15'h4000, 8'h00}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [14:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic req_ready, rsp_valid, mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [7:0]  rsp_data, mem_dq_out, mem_dq_in;
  logic [14:0] mem_addr;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  sram_ctrl #(
    .SETUP_CYC(SETUP_CYC), .PULSE_CYC(PULSE_CYC), .RECOV_CYC(RECOV_CYC),
    .ACCESS_CYC(ACCESS_CYC), .TURN_CYC(TURN_CYC)
  ) i_sram_ctrl (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .mem_addr(mem_addr),
    .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
    .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // small associative memory model
  logic [14:0] m_addr [SLOTS];
  logic [7:0]  m_data [SLOTS];
  logic        m_val  [SLOTS];
  int          m_fill = 0;

  initial for (int i = 0; i < SLOTS; i++) m_val[i] = 1'b0;

  always_comb begin
    mem_dq_in = 8'hEE;
    if (!mem_cs_n && !mem_oe_n && mem_we_n)
      for (int i = 0; i < SLOTS; i++)
        if (m_val[i] && m_addr[i] == mem_addr) mem_dq_in = m_data[i];
  end

  always @(posedge clk) begin
    if (!mem_cs_n && !mem_we_n) begin : wr
      int slot;
      slot = -1;
      for (int i = 0; i < SLOTS; i++)
        if (m_val[i] && m_addr[i] == mem_addr) slot = i;
      if (slot < 0) begin
        slot = m_fill;
        m_fill <= m_fill + 1;
      end
      m_addr[slot] <= mem_addr;
      m_data[slot] <= mem_dq_oe ? mem_dq_out : 8'h11;
      m_val[slot]  <= 1'b1;
    end
  end

  // pin-sequence monitor, sampled at the falling edge
  int we_run = 0, oe_run = 0, setup_run = 0, turn_run = 0, rec_run = 0;
  bit in_rec = 0;
  logic p_we = 1'b1, p_oe = 1'b1, p_dq = 1'b0, p_cs = 1'b1;

  always @(negedge clk) begin
    if (rst) begin
      we_run = 0; oe_run = 0; setup_run = 0; turn_run = 0; rec_run = 0; in_rec = 0;
    end else begin
      if (mem_dq_oe && !mem_oe_n) chk(0, "R5 contention", 1, 0);
      if (!mem_we_n) begin
        if (we_run == 0) chk(setup_run == SETUP_CYC, "R6 setup cycles", setup_run, SETUP_CYC);
        we_run++;
      end else if (we_run != 0) begin
        chk(we_run == PULSE_CYC, "R4 pulse cycles", we_run, PULSE_CYC);
        chk(!mem_dq_oe, "R6 release with strobe", mem_dq_oe, 0);
        we_run = 0; setup_run = 0; in_rec = 1; rec_run = 0;
      end
      if (mem_dq_oe && mem_we_n) setup_run++;
      if (!mem_oe_n) oe_run++;
      else if (oe_run != 0) begin
        chk(oe_run == ACCESS_CYC, "R2 access cycles", oe_run, ACCESS_CYC);
        oe_run = 0; in_rec = 1; rec_run = 0;
      end
      if (mem_dq_oe && !p_dq) begin
        chk(turn_run >= TURN_CYC, "R5 turnaround", turn_run, TURN_CYC);
        turn_run = 0;
      end
      if (!mem_cs_n && mem_oe_n && !mem_dq_oe && mem_we_n) turn_run++;
      if (mem_cs_n) turn_run = 0;
      if (in_rec) begin
        if (mem_cs_n) begin
          chk(rec_run == RECOV_CYC, "R7 recovery", rec_run, RECOV_CYC);
          in_rec = 0;
        end else rec_run++;
      end
    end
    p_we = mem_we_n; p_oe = mem_oe_n; p_dq = mem_dq_oe; p_cs = mem_cs_n;
  end

  task automatic check_idle(input string tag);
    chk(mem_cs_n == 1'b1, {tag, " cs_n"}, mem_cs_n, 1);
    chk(mem_we_n == 1'b1, {tag, " we_n"}, mem_we_n, 1);
    chk(mem_oe_n == 1'b1, {tag, " oe_n"}, mem_oe_n, 1);
    chk(mem_dq_oe == 1'b0, {tag, " dq_oe"}, mem_dq_oe, 0);
    chk(req_ready == 1'b1, {tag, " ready"}, req_ready, 1);
    chk(rsp_valid == 1'b0, {tag, " rsp_valid"}, rsp_valid, 0);
  endtask

  task automatic wait_ready();
    int n = 0;
    while (!req_ready && n < 100) begin @(negedge clk); n++; end
  endtask

  task automatic do_req(input logic wr, input logic [14:0] a, input logic [7:0] d);
    int lat;
    wait_ready();
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    chk(!req_ready, "R8 busy after accept", req_ready, 0);
    if (!wr) begin
      chk(!mem_oe_n && mem_addr == a, "R2 address on read", mem_addr, a);
      lat = 1;
      while (!rsp_valid && lat < 50) begin @(negedge clk); lat++; end
      chk(lat == ACCESS_CYC + 1, "R3 latency", lat, ACCESS_CYC + 1);
      chk(rsp_data == d, "R3 read data", rsp_data, d);
      @(negedge clk);
      chk(!rsp_valid, "R3 strobe one cycle", rsp_valid, 0);
    end else begin
      while (!req_ready) @(negedge clk);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check_idle("R1 reset");
    rst = 1'b0;
    @(negedge clk);
    check_idle("R1 idle");

    for (int v = 0; v < NVEC; v++)
      do_req(VEC[v][23], VEC[v][22:8], VEC[v][7:0]);
    @(negedge clk);
    check_idle("R1 after traffic");

    // held request across a busy store (R8) then load of the same byte (R4)
    wait_ready();
    req_valid = 1'b1; req_write = 1'b1; req_addr = 15'h2AAA; req_wdata = 8'h96;
    @(negedge clk);
    chk(!req_ready, "R8 ready low while busy", req_ready, 0);
    req_write = 1'b0; req_wdata = 8'h00;
    begin
      int n = 0;
      while (!req_ready && n < 100) begin
        @(negedge clk);
        if (!mem_oe_n) chk(0, "R8 taken while busy", 1, 0);
        n++;
      end
    end
    @(negedge clk);
    req_valid = 1'b0;
    begin
      int n = 0;
      while (!rsp_valid && n < 50) begin @(negedge clk); n++; end
    end
    chk(rsp_data == 8'h96, "R4 held store then load", rsp_data, 8'h96);
    wait_ready();

    // reset in the middle of the write strobe
    req_valid = 1'b1; req_write = 1'b1; req_addr = 15'h0101; req_wdata = 8'h77;
    @(negedge clk);
    req_valid = 1'b0;
    begin
      int n = 0;
      while (mem_we_n && n < 50) begin @(negedge clk); n++; end
    end
    rst = 1'b1;
    @(negedge clk);
    check_idle("R1 mid-write reset");
    rst = 1'b0;
    @(negedge clk);
    do_req(1'b0, 15'h7FFF, 8'h5A);

    repeat (4) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      chk(0, "watchdog", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule